// File: doc/BRIEF.md
# Register Stack Save/Restore Sequencer

This block moves a chosen group of processor registers between the register file and a byte-wide memory, using either the system stack pointer (S) or the user stack pointer (U). A one-cycle start pulse presents an opcode and an 8-bit selection mask. The block then runs a fixed lead-in, one memory cycle per byte moved, and a short tail. It walks the selected registers in one order when saving and in the reverse order when restoring.

A save stores bytes at descending addresses, decrementing the pointer before each write. A restore reads at ascending addresses, incrementing the pointer after each read. The pointer in use, the restored register values and the total cycle cost of the operation are all available once the done pulse appears. Opcode fetch and interrupt entry stay with the surrounding core. The core presents the current register values with the start pulse, and it takes the results back on done.

Top module: `regstk_seq`

## Requirements
- R1: A start pulse is accepted only when the block is idle and the opcode is 0x34 (save on S), 0x35 (restore from S), 0x36 (save on U) or 0x37 (restore from U). A start with any other opcode, or a start while busy, is ignored.
- R2: Mask bit 0 selects CC, bit 1 A, bit 2 B, bit 3 DP, bit 4 X, bit 5 Y, bit 6 the other stack pointer (U for S operations, S for U operations) and bit 7 PC. The 8-bit registers move one byte each; the 16-bit registers move two bytes each.
- R3: `busy` stays high for exactly 5 + N cycles, starting the cycle after an accepted start, where N is the number of bytes moved. `done` is a one-cycle pulse in the last busy cycle.
- R4: `cyc_count` takes the value 5 + N when a start is accepted and holds it until the next accepted start. It is 0 after reset.
- R5: A save writes PC low, PC high, other-pointer low, other-pointer high, Y low, Y high, X low, X high, DP, B, A, CC, skipping any register not selected. Each byte goes to pointer − 1, and the pointer then becomes that address, so every 16-bit register ends up high byte at the lower address.
- R6: A restore reads CC, A, B, DP, X high, X low, Y high, Y low, other-pointer high, other-pointer low, PC high, PC low, skipping any register not selected. Each byte is read at the pointer, and the pointer then increments.
- R7: After done, `sp_out` holds the selected stack pointer minus N for a save, or plus N for a restore. `sp_out` does not change while the block is idle.
- R8: The register outputs carry the values restored from memory for the selected registers. For unselected registers, and for every register of a save, they carry the input values captured at start.
- R9: An empty mask moves no bytes, leaves the pointer unchanged and still takes 5 busy cycles.
- R10: `mem_we` is high only in the transfer cycles of a save, once per byte. It is never high during a restore or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle with a valid opcode |
| opcode | input | 8 | Operation select, 0x34 to 0x37 |
| postbyte | input | 8 | Register selection mask |
| cc_in | input | DW | Current condition code register |
| a_in | input | DW | Current accumulator A |
| b_in | input | DW | Current accumulator B |
| dp_in | input | DW | Current direct page register |
| x_in | input | 2*DW | Current index X |
| y_in | input | 2*DW | Current index Y |
| u_in | input | 2*DW | Current user stack pointer |
| s_in | input | 2*DW | Current system stack pointer |
| pc_in | input | 2*DW | Current program counter |
| mem_addr | output | 2*DW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle as the address |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| cyc_count | output | 5 | Total cycles of the last accepted operation |
| sp_out | output | 2*DW | Updated pointer of the stack in use |
| cc_out | output | DW | Resulting CC |
| a_out | output | DW | Resulting A |
| b_out | output | DW | Resulting B |
| dp_out | output | DW | Resulting DP |
| x_out | output | 2*DW | Resulting X |
| y_out | output | 2*DW | Resulting Y |
| other_sp_out | output | 2*DW | Resulting other stack pointer |
| pc_out | output | 2*DW | Resulting PC |

## Verification
The bench does a full save followed by a full restore on S. A reversed walk or a misplaced pointer decrement would then leave swapped byte pairs in memory, or restore scrambled registers. It saves and restores a pair of registers on U that includes the other-pointer bit, which catches a design that confuses the two stacks or passes the input through instead of the restored value. It runs an empty mask to catch a design that hangs or writes anyway with nothing selected. It also holds start high during an operation and applies a bad opcode, which would expose a sequencer that restarts or corrupts the cycle count.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

  // byte slots in restore order: 0 CC, 1 A, 2 B, 3 DP, 4/5 X hi/lo,
  // 6/7 Y hi/lo, 8/9 other pointer hi/lo, 10/11 PC hi/lo
  localparam int unsigned NSLOT = 12;

  localparam logic [5:0] OPC_GROUP = 6'b001101;  // 0x34..0x37

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_t;

  // expand the register mask to one enable per byte slot
  function automatic logic [NSLOT-1:0] slot_enables(input logic [7:0] m);
    return {m[7], m[7], m[6], m[6], m[5], m[5], m[4], m[4],
            m[3], m[2], m[1], m[0]};
  endfunction

endpackage

// File: rtl/regstk_pick.sv
// Selects the next pending slot: highest first for a save, lowest for a restore
module regstk_pick #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          hi_first,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hi_first) begin
        if (pend[i]) idx = IW'(i);
      end else begin
        if (pend[N-1-i]) idx = IW'(N-1-i);
      end
    end
  end

endmodule

// File: rtl/regstk_count.sv
// Total cycle cost: fixed overhead plus one per selected byte
module regstk_count #(
  parameter int N    = 12,
  parameter int BASE = 5,
  parameter int CW   = 5
) (
  input  logic [N-1:0]  sel,
  output logic [CW-1:0] total
);

  always_comb begin
    total = CW'(BASE);
    for (int i = 0; i < N; i++) begin
      total = total + CW'(sel[i]);
    end
  end

endmodule

// File: rtl/regstk_slotfile.sv
// One byte register per slot: loaded from the inputs at start, overwritten on reads
module regstk_slotfile #(
  parameter int N  = 12,
  parameter int DW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N*DW-1:0] ld_vec,
  input  logic          wr,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdat,
  output logic [N*DW-1:0] q
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [DW-1:0] byte_q;
    logic [DW-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (load) begin
        byte_d = ld_vec[g*DW +: DW];
      end else if (wr && (widx == IW'(g))) begin
        byte_d = wdat;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (load || wr) begin
        byte_q <= byte_d;
      end
    end

    assign q[g*DW +: DW] = byte_q;
  end

endmodule

// File: rtl/regstk_seq.sv
module regstk_seq
  import regstk_pkg::*;
#(
  parameter int DW       = 8,
  parameter int LEAD_CYC = 3,
  parameter int TAIL_CYC = 2,
  localparam int WW      = 2 * DW,
  localparam int CW      = $clog2(LEAD_CYC + TAIL_CYC + NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [7:0]    postbyte,
  input  logic [DW-1:0] cc_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] dp_in,
  input  logic [WW-1:0] x_in,
  input  logic [WW-1:0] y_in,
  input  logic [WW-1:0] u_in,
  input  logic [WW-1:0] s_in,
  input  logic [WW-1:0] pc_in,
  output logic [WW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cyc_count,
  output logic [WW-1:0] sp_out,
  output logic [DW-1:0] cc_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out,
  output logic [DW-1:0] dp_out,
  output logic [WW-1:0] x_out,
  output logic [WW-1:0] y_out,
  output logic [WW-1:0] other_sp_out,
  output logic [WW-1:0] pc_out
);

  localparam int IW   = $clog2(NSLOT);
  localparam int PW   = $clog2(LEAD_CYC + TAIL_CYC + 1);
  localparam int BASE = LEAD_CYC + TAIL_CYC;

  seq_state_t      st_q, st_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic [NSLOT-1:0] pend_q, pend_d;
  logic [WW-1:0]   sp_q, sp_d;
  logic            pull_q, pull_d;
  logic [CW-1:0]   cyc_q, cyc_d;

  logic            op_ok, accept, xfer;
  logic [NSLOT-1:0] sel_new;
  logic [CW-1:0]   total_new;
  logic [IW-1:0]   idx;
  logic [WW-1:0]   sp_pick, osp_pick;
  logic [NSLOT*DW-1:0] ld_vec, sf_q;

  assign op_ok    = (opcode[7:2] == OPC_GROUP);
  assign accept   = start && op_ok && (st_q == ST_IDLE);
  assign xfer     = (st_q == ST_XFER);
  assign sel_new  = slot_enables(postbyte);
  assign sp_pick  = opcode[1] ? u_in : s_in;
  assign osp_pick = opcode[1] ? s_in : u_in;

  // slot 11 (PC low) in the top byte down to slot 0 (CC)
  assign ld_vec = {pc_in[DW-1:0], pc_in[WW-1:DW],
                   osp_pick[DW-1:0], osp_pick[WW-1:DW],
                   y_in[DW-1:0], y_in[WW-1:DW],
                   x_in[DW-1:0], x_in[WW-1:DW],
                   dp_in, b_in, a_in, cc_in};

  regstk_count #(.N(NSLOT), .BASE(BASE), .CW(CW)) u_count (
    .sel   (sel_new),
    .total (total_new)
  );

  regstk_pick #(.N(NSLOT), .IW(IW)) u_pick (
    .pend     (pend_q),
    .hi_first (!pull_q),
    .idx      (idx)
  );

  regstk_slotfile #(.N(NSLOT), .DW(DW), .IW(IW)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .ld_vec (ld_vec),
    .wr     (xfer && pull_q),
    .widx   (idx),
    .wdat   (mem_rdata),
    .q      (sf_q)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    pend_d = pend_q;
    sp_d   = sp_q;
    pull_d = pull_q;
    cyc_d  = cyc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_LEAD;
          ph_d   = '0;
          pend_d = sel_new;
          sp_d   = sp_pick;
          pull_d = opcode[0];
          cyc_d  = total_new;
        end
      end
      ST_LEAD: begin
        if (ph_q == PW'(LEAD_CYC - 1)) begin
          ph_d = '0;
          st_d = (|pend_q) ? ST_XFER : ST_TAIL;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_XFER: begin
        pend_d = pend_q & ~(NSLOT'(1) << idx);
        sp_d   = pull_q ? (sp_q + 1'b1) : (sp_q - 1'b1);
        if (pend_d == '0) st_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (ph_q == PW'(TAIL_CYC - 1)) begin
          ph_d = '0;
          st_d = ST_IDLE;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      pend_q <= '0;
      sp_q   <= '0;
      pull_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      pend_q <= pend_d;
      sp_q   <= sp_d;
      pull_q <= pull_d;
      cyc_q  <= cyc_d;
    end
  end

  assign mem_addr  = pull_q ? sp_q : (sp_q - 1'b1);
  assign mem_wdata = sf_q[idx*DW +: DW];
  assign mem_we    = xfer && !pull_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_TAIL) && (ph_q == PW'(TAIL_CYC - 1));
  assign cyc_count = cyc_q;
  assign sp_out    = sp_q;

  assign cc_out       = sf_q[0*DW +: DW];
  assign a_out        = sf_q[1*DW +: DW];
  assign b_out        = sf_q[2*DW +: DW];
  assign dp_out       = sf_q[3*DW +: DW];
  assign x_out        = {sf_q[4*DW +: DW], sf_q[5*DW +: DW]};
  assign y_out        = {sf_q[6*DW +: DW], sf_q[7*DW +: DW]};
  assign other_sp_out = {sf_q[8*DW +: DW], sf_q[9*DW +: DW]};
  assign pc_out       = {sf_q[10*DW +: DW], sf_q[11*DW +: DW]};

endmodule

module regstk_seq_chk #(
  parameter int WW   = 16,
  parameter int CW   = 5,
  parameter int BASE = 5,
  parameter int MAXC = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic [WW-1:0] mem_addr,
  input logic [WW-1:0] sp_out,
  input logic [CW-1:0] cyc_count,
  input logic          xfer,
  input logic          pull_op
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R3

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);  // R3

  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((cyc_count >= CW'(BASE)) && (cyc_count <= CW'(MAXC))));  // R4

  AST_SAVE_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(mem_addr)));  // R5

  AST_RESTORE_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && pull_op) |=> (sp_out == $past(mem_addr) + 1'b1));  // R6

  AST_SP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(sp_out));  // R7

  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);  // R10

  AST_NO_WE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pull_op) |-> !mem_we);  // R10

endmodule

bind regstk_seq regstk_seq_chk #(
  .WW(WW), .CW(CW), .BASE(BASE), .MAXC(BASE + NSLOT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .sp_out    (sp_out),
  .cyc_count (cyc_count),
  .xfer      (xfer),
  .pull_op   (pull_q)
);

// File: tb/regstk_seq_tb.sv
module regstk_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  V_CC = 8'hC5, V_A = 8'h1A, V_B = 8'h2B, V_DP = 8'h3D;
  localparam logic [15:0] V_X = 16'h4455, V_Y = 16'h6677, V_U = 16'h01C0,
                          V_S = 16'h0180, V_PC = 16'h8899;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00, postbyte = 8'h00;
  logic [7:0]  cc_in, a_in, b_in, dp_in;
  logic [15:0] x_in, y_in, u_in, s_in, pc_in;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, busy, done;
  logic [4:0]  cyc_count;
  logic [15:0] sp_out;
  logic [7:0]  cc_out, a_out, b_out, dp_out;
  logic [15:0] x_out, y_out, other_sp_out, pc_out;

  int checks = 0;
  int errors = 0;
  int cycles;
  int wr_total = 0;
  int wr_before, wr_n;
  logic [7:0]  mem [0:255];
  logic [15:0] log_a [0:15];
  logic [7:0]  log_d [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  regstk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .postbyte(postbyte),
    .cc_in(cc_in), .a_in(a_in), .b_in(b_in), .dp_in(dp_in),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .s_in(s_in), .pc_in(pc_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .busy(busy), .done(done), .cyc_count(cyc_count), .sp_out(sp_out),
    .cc_out(cc_out), .a_out(a_out), .b_out(b_out), .dp_out(dp_out),
    .x_out(x_out), .y_out(y_out), .other_sp_out(other_sp_out), .pc_out(pc_out)
  );

  // byte memory model, combinational read
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      log_a[wr_total[3:0]] <= mem_addr;
      log_d[wr_total[3:0]] <= mem_wdata;
      wr_total <= wr_total + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_regs();
    cc_in = V_CC; a_in = V_A; b_in = V_B; dp_in = V_DP;
    x_in = V_X; y_in = V_Y; u_in = V_U; s_in = V_S; pc_in = V_PC;
  endtask

  // hold != 0 keeps start high, with another opcode, while busy
  task automatic run_op(input logic [7:0] op, input logic [7:0] m, input bit hold);
    bit got_done;
    wr_before = wr_total;
    @(negedge clk);
    opcode = op; postbyte = m; start = 1'b1;
    @(negedge clk);
    if (hold) opcode = 8'h35;
    else start = 1'b0;
    cycles = 0;
    got_done = 1'b0;
    for (int k = 0; k < 40 && !got_done; k++) begin
      if (busy) cycles++;
      if (done) got_done = 1'b1;
      else @(negedge clk);
    end
    start = 1'b0;
    wr_n = wr_total - wr_before;
  endtask

  task automatic t_reset();
    check("R3 busy after reset", busy, 0);
    check("R3 done after reset", done, 0);
    check("R10 we after reset", mem_we, 0);
    check("R4 count after reset", cyc_count, 0);
  endtask

  task automatic t_save_s_full();
    logic [7:0] img [0:11];
    img = '{V_CC, V_A, V_B, V_DP, V_X[15:8], V_X[7:0], V_Y[15:8], V_Y[7:0],
            V_U[15:8], V_U[7:0], V_PC[15:8], V_PC[7:0]};
    set_regs();
    run_op(8'h34, 8'hFF, 1'b0);
    check("R3 full save cycles", cycles, 17);
    check("R4 full save count", cyc_count, 17);
    check("R10 full save writes", wr_n, 12);
    check("R7 full save pointer", sp_out, 16'h0174);
    check("R5 first write addr", log_a[wr_before % 16], 16'h017F);
    check("R5 first write data", log_d[wr_before % 16], V_PC[7:0]);
    check("R5 last write addr", log_a[(wr_before + 11) % 16], 16'h0174);
    for (int i = 0; i < 12; i++) begin
      check("R2 R5 stack image", mem[8'h74 + i], img[i]);
    end
    check("R8 save keeps pc", pc_out, V_PC);
    check("R8 save keeps x", x_out, V_X);
  endtask

  task automatic t_restore_s_full();
    cc_in = 8'h00; a_in = 8'h00; b_in = 8'h00; dp_in = 8'h00;
    x_in = 16'h0; y_in = 16'h0; u_in = 16'h0BAD; pc_in = 16'h0; s_in = 16'h0174;
    run_op(8'h35, 8'hFF, 1'b0);
    check("R3 full restore cycles", cycles, 17);
    check("R10 no writes on restore", wr_n, 0);
    check("R7 restore pointer", sp_out, V_S);
    check("R6 cc", cc_out, V_CC);
    check("R6 a", a_out, V_A);
    check("R6 b", b_out, V_B);
    check("R6 dp", dp_out, V_DP);
    check("R6 x", x_out, V_X);
    check("R6 y", y_out, V_Y);
    check("R6 other pointer", other_sp_out, V_U);
    check("R6 pc", pc_out, V_PC);
  endtask

  task automatic t_save_u_pair();
    set_regs();
    run_op(8'h36, 8'h41, 1'b0);
    check("R3 pair save cycles", cycles, 8);
    check("R2 pair cc", mem[8'hBD], V_CC);
    check("R2 pair s hi", mem[8'hBE], V_S[15:8]);
    check("R2 pair s lo", mem[8'hBF], V_S[7:0]);
    check("R5 pair first addr", log_a[wr_before % 16], 16'h01BF);
    check("R7 pair pointer", sp_out, 16'h01BD);
  endtask

  task automatic t_restore_u_pair();
    set_regs();
    cc_in = 8'h00; a_in = 8'h77; s_in = 16'h0222; u_in = 16'h01BD;
    run_op(8'h37, 8'h41, 1'b0);
    check("R3 pair restore cycles", cycles, 8);
    check("R6 pair cc", cc_out, V_CC);
    check("R6 pair other pointer", other_sp_out, V_S);
    check("R8 unselected a", a_out, 8'h77);
    check("R8 unselected x", x_out, V_X);
    check("R7 pair restore pointer", sp_out, V_U);
    check("R10 pair restore writes", wr_n, 0);
  endtask

  task automatic t_empty();
    set_regs();
    u_in = 16'h01A0;
    run_op(8'h36, 8'h00, 1'b0);
    check("R9 empty cycles", cycles, 5);
    check("R9 empty count", cyc_count, 5);
    check("R9 empty writes", wr_n, 0);
    check("R9 empty pointer", sp_out, 16'h01A0);
  endtask

  task automatic t_pc_only();
    set_regs();
    run_op(8'h36, 8'h80, 1'b0);
    check("R3 pc save cycles", cycles, 7);
    check("R2 pc hi", mem[8'hBE], V_PC[15:8]);
    check("R2 pc lo", mem[8'hBF], V_PC[7:0]);
    check("R7 pc pointer", sp_out, 16'h01BE);
  endtask

  task automatic t_bad_opcode();
    wr_before = wr_total;
    @(negedge clk);
    opcode = 8'h38; postbyte = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 bad opcode busy", busy, 0);
    @(negedge clk);
    check("R1 bad opcode busy later", busy, 0);
    check("R4 bad opcode count held", cyc_count, 7);
    check("R1 bad opcode writes", wr_total - wr_before, 0);
  endtask

  task automatic t_start_while_busy();
    set_regs();
    run_op(8'h34, 8'h03, 1'b1);
    check("R1 busy-start cycles", cycles, 7);
    check("R1 busy-start count", cyc_count, 7);
    check("R1 busy-start writes", wr_n, 2);
    check("R5 busy-start a", mem[8'h7F], V_A);
    check("R5 busy-start cc", mem[8'h7E], V_CC);
    check("R7 busy-start pointer", sp_out, 16'h017E);
    @(negedge clk);
    check("R1 idle after op", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    set_regs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_save_s_full();
    t_restore_s_full();
    t_save_u_pair();
    t_restore_u_pair();
    t_empty();
    t_pc_only();
    t_bad_opcode();
    t_start_while_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule